// File: doc/BRIEF.md
# LED Software Override Blink Controller

This block lets management software take over a bank of port LEDs. Commands arrive as a parallel byte qualified by a one-cycle strobe. One command sets a blink period that every overridden LED shares. A second command adds a group of LEDs to a sticky override mask. The group can be one twisted-pair port, an AUI port, a set of ports, or a global indicator.

The block drives twelve active-low LEDs: eight twisted-pair ports, a primary and a secondary AUI port, and a primary and a secondary global indicator. An LED outside the override mask follows its normal hardware status input without any delay. An LED inside the mask follows the shared blink state, which switches between driven low and off (high). The blink timing is derived from the system clock through the `CYCLES_PER_MS` prescaler parameter, so simulation can use short periods.

Top module: `led_blink_override`

## Requirements
- R1: After reset the period setting is off and no LED is overridden, so every output equals its status input.
- R2: A strobed byte whose upper six bits are 111010 stores its low two bits as the period: 00 off, 01 fast, 10 slow, 11 steady. The period holds until the next such byte.
- R3: A strobed byte whose upper nibble is 1100 with a low nibble from 0000 to 0111 overrides twisted-pair port n, where n is that nibble. Mask bits 0–7 hold the twisted-pair ports.
- R4: Group codes act as follows. 1000 overrides the primary AUI (mask bit 8). 1001 overrides the secondary AUI (bit 9). 1010 overrides both AUI ports. 1011 overrides all eight twisted-pair ports. 1100 overrides all twisted-pair and AUI ports.
- R5: Group code 1101 overrides the primary global LED (bit 10), and 1110 overrides the secondary global LED (bit 11).
- R6: Override commands OR into the mask. No command removes a bit; only reset clears the mask.
- R7: With period off, every overridden LED is held high (off), whatever its input.
- R8: With period steady, every overridden LED is held low, whatever its input.
- R9: With period fast, overridden LEDs stay low for 256·CYCLES_PER_MS cycles and then high for the same span, repeating. All overridden LEDs are in step.
- R10: With period slow, the low and high spans are each 780·CYCLES_PER_MS cycles.
- R11: An LED not in the mask follows its status input in the same cycle, even while other LEDs are overridden.
- R12: The following change neither the mask nor the period: bytes without the strobe, group code 1111, and bytes with any other upper bits.
- R13: Each period write restarts the blink phase. Overridden LEDs go low in the cycle after the write and hold low for a full half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe qualifying cmd_byte for one cycle |
| cmd_byte | input | 8 | Management command byte |
| tp_led_in | input | 8 | Normal active-low twisted-pair LED status |
| aui_led_in | input | 2 | Normal active-low AUI LED status, bit 0 primary |
| glb_led_in | input | 2 | Normal active-low global LED status, bit 0 primary |
| tp_led_n | output | 8 | Twisted-pair LED drive, low = lit |
| aui_led_n | output | 2 | AUI LED drive, low = lit |
| glb_led_n | output | 2 | Global LED drive, low = lit |

## Verification
The bench checks the blink edges at the exact cycle on both sides of each half-period boundary. A design with an off-by-one in the prescaler or millisecond count, or with a duty cycle other than half, shows the wrong level there. It checks the group codes one at a time against LEDs whose inputs show the opposite level, so a decode that sets the wrong bit or misses a port is exposed. It also checks that later commands only add to the mask. It rewrites the period in mid-blink, which catches a design that keeps its old phase. It then checks that unused group codes, foreign opcodes and unstrobed bytes leave the outputs as they were.

// File: rtl/led_blink_override.sv
module led_blink_override #(
  parameter int CYCLES_PER_MS = 1000,
  parameter int FAST_HALF_MS  = 256,
  parameter int SLOW_HALF_MS  = 780
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] tp_led_in,
  input  logic [1:0] aui_led_in,
  input  logic [1:0] glb_led_in,
  output logic [7:0] tp_led_n,
  output logic [1:0] aui_led_n,
  output logic [1:0] glb_led_n
);
  localparam int PRE_W = $clog2(CYCLES_PER_MS + 1);
  localparam int MS_W  = $clog2(SLOW_HALF_MS + 1);
  localparam logic [1:0] RATE_OFF   = 2'b00;
  localparam logic [1:0] RATE_FAST  = 2'b01;
  localparam logic [1:0] RATE_STEADY = 2'b11;

  logic [1:0]       rate_q;
  logic [11:0]      ovr_mask;
  logic             phase_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic [11:0]      grp_mask;
  logic [MS_W-1:0]  half_m1;

  wire is_rate  = cmd_valid && (cmd_byte[7:2] == 6'b111010);
  wire is_ovr   = cmd_valid && (cmd_byte[7:4] == 4'b1100);
  wire blinking = (rate_q != RATE_OFF) && (rate_q != RATE_STEADY);
  wire ms_tick  = (pre_q == PRE_W'(CYCLES_PER_MS - 1));
  wire lit      = (rate_q == RATE_STEADY) || (blinking && phase_q);

  assign half_m1 = (rate_q == RATE_FAST) ? MS_W'(FAST_HALF_MS - 1)
                                         : MS_W'(SLOW_HALF_MS - 1);

  always_comb begin
    grp_mask = '0;
    case (cmd_byte[3:0])
      4'b1000: grp_mask[8]     = 1'b1;
      4'b1001: grp_mask[9]     = 1'b1;
      4'b1010: grp_mask[9:8]   = 2'b11;
      4'b1011: grp_mask[7:0]   = 8'hFF;
      4'b1100: grp_mask[9:0]   = 10'h3FF;
      4'b1101: grp_mask[10]    = 1'b1;
      4'b1110: grp_mask[11]    = 1'b1;
      4'b1111: grp_mask        = '0;
      default: grp_mask[cmd_byte[2:0]] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q   <= RATE_OFF;
      ovr_mask <= '0;
    end else begin
      if (is_rate) rate_q <= cmd_byte[1:0];
      if (is_ovr)  ovr_mask <= ovr_mask | grp_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || is_rate || !blinking) begin
      pre_q   <= '0;
      ms_q    <= '0;
      phase_q <= 1'b1;
    end else if (ms_tick) begin
      pre_q <= '0;
      if (ms_q == half_m1) begin
        ms_q    <= '0;
        phase_q <= ~phase_q;
      end else begin
        ms_q <= ms_q + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  wire drive_n = ~lit;

  assign tp_led_n  = (ovr_mask[7:0]   & {8{drive_n}}) | (~ovr_mask[7:0]   & tp_led_in);
  assign aui_led_n = (ovr_mask[9:8]   & {2{drive_n}}) | (~ovr_mask[9:8]   & aui_led_in);
  assign glb_led_n = (ovr_mask[11:10] & {2{drive_n}}) | (~ovr_mask[11:10] & glb_led_in);
endmodule

// File: rtl/led_blink_override_chk.sv
module led_blink_override_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_byte,
  input logic [7:0]  tp_led_in,
  input logic [1:0]  aui_led_in,
  input logic [1:0]  glb_led_in,
  input logic [7:0]  tp_led_n,
  input logic [1:0]  aui_led_n,
  input logic [1:0]  glb_led_n,
  input logic [11:0] ovr_mask,
  input logic [1:0]  rate_q
);
  wire [11:0] outs = {glb_led_n, aui_led_n, tp_led_n};
  wire [11:0] ins  = {glb_led_in, aui_led_in, tp_led_in};

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovr_mask & $past(ovr_mask)) == $past(ovr_mask))); // R6
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rate_q)); // R2
  AST_BAD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte == 8'hCF) |=> $stable(ovr_mask)); // R12
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    ((outs & ~ovr_mask) == (ins & ~ovr_mask))); // R11
  AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b00) |-> ((outs & ovr_mask) == ovr_mask)); // R7
  AST_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b11) |-> ((outs & ovr_mask) == 12'h000)); // R8
  AST_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (((outs & ovr_mask) == 12'h000) || ((outs & ovr_mask) == ovr_mask))); // R9
endmodule

bind led_blink_override led_blink_override_chk u_chk (.*);

// File: tb/test_led_blink_override.sv
`timescale 1ns/1ps
module test_led_blink_override;
  localparam int CPM = 2;
  localparam int FAST = 256 * CPM;
  localparam int SLOW = 780 * CPM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] tp_led_in = 8'h00;
  logic [1:0] aui_led_in = 2'b00;
  logic [1:0] glb_led_in = 2'b00;
  logic [7:0] tp_led_n;
  logic [1:0] aui_led_n;
  logic [1:0] glb_led_n;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_mask = '0;
  logic        exp_lit  = 1'b0;

  always #2.5 clk = ~clk;

  led_blink_override #(.CYCLES_PER_MS(CPM)) i_led_blink_override (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .tp_led_in(tp_led_in), .aui_led_in(aui_led_in), .glb_led_in(glb_led_in),
    .tp_led_n(tp_led_n), .aui_led_n(aui_led_n), .glb_led_n(glb_led_n));

  task automatic check_all(input string tag);
    logic [11:0] ins, exp, got;
    #1;
    ins = {glb_led_in, aui_led_in, tp_led_in};
    exp = (exp_mask & {12{~exp_lit}}) | (~exp_mask & ins);
    got = {glb_led_n, aui_led_n, tp_led_n};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: leds actual %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    tp_led_in = 8'hA5; aui_led_in = 2'b10; glb_led_in = 2'b01;
    check_all("R1 reset pass pattern A");
    tp_led_in = 8'h3C; aui_led_in = 2'b01; glb_led_in = 2'b10;
    check_all("R1 reset pass pattern B");
  endtask

  task automatic t_ignore;
    send(8'hCF); send(8'h00); send(8'hE4); send(8'hD3); send(8'hEF);
    @(negedge clk); cmd_byte = 8'hC0; cmd_valid = 1'b0;
    @(negedge clk);
    tp_led_in = 8'h00; aui_led_in = 2'b00; glb_led_in = 2'b00;
    check_all("R12 ignored bytes leave mask empty");
  endtask

  task automatic t_single_off;
    tp_led_in = 8'h00;
    send(8'hC3);
    exp_mask[3] = 1'b1; exp_lit = 1'b0;
    check_all("R3 R7 tp3 forced off");
    tp_led_in = 8'hF7; aui_led_in = 2'b11;
    check_all("R11 unmasked LEDs follow inputs");
    tp_led_in = 8'h00; aui_led_in = 2'b00;
    check_all("R11 unmasked LEDs follow inputs again");
  endtask

  task automatic t_groups;
    send(8'hC8); exp_mask[8] = 1'b1;
    check_all("R4 primary AUI");
    send(8'hC9); exp_mask[9] = 1'b1;
    check_all("R4 R6 secondary AUI accumulates");
    send(8'hCB); exp_mask[7:0] = 8'hFF;
    check_all("R4 all TP");
    send(8'hCD); exp_mask[10] = 1'b1;
    check_all("R5 primary global");
    send(8'hCE); exp_mask[11] = 1'b1;
    check_all("R5 secondary global");
  endtask

  task automatic t_group_wide;
    rst_n = 1'b0; wait_n(2); rst_n = 1'b1;
    exp_mask = '0; exp_lit = 1'b0;
    check_all("R1 reset clears mask");
    send(8'hCA); exp_mask[9:8] = 2'b11;
    check_all("R4 both AUI");
    rst_n = 1'b0; wait_n(2); rst_n = 1'b1;
    exp_mask = '0;
    send(8'hCC); exp_mask[9:0] = 10'h3FF;
    check_all("R4 all ports");
    send(8'hCD); send(8'hCE); exp_mask[11:10] = 2'b11;
  endtask

  task automatic t_steady;
    tp_led_in = 8'hFF; aui_led_in = 2'b11; glb_led_in = 2'b11;
    send(8'hEB); exp_lit = 1'b1;
    check_all("R2 R8 steady drives low");
    send(8'hE8); exp_lit = 1'b0;
    tp_led_in = 8'h00; aui_led_in = 2'b00; glb_led_in = 2'b00;
    check_all("R2 R7 period off drives high");
  endtask

  task automatic t_blink(input logic [7:0] b, input int half, input string tag);
    send(b); exp_lit = 1'b1;
    check_all({tag, " lit after write"});
    wait_n(half - 1);
    check_all({tag, " lit at end of first half"});
    wait_n(1); exp_lit = 1'b0;
    check_all({tag, " off at half boundary"});
    wait_n(half - 1);
    check_all({tag, " off at end of second half"});
    wait_n(1); exp_lit = 1'b1;
    check_all({tag, " lit again after full period"});
  endtask

  task automatic t_restart;
    send(8'hE9); wait_n(300);
    send(8'hE9); exp_lit = 1'b1;
    check_all("R13 restart lit");
    wait_n(FAST - 1);
    check_all("R13 restart holds full half");
    wait_n(1); exp_lit = 1'b0;
    check_all("R13 restart toggles on new schedule");
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    t_ignore();
    t_single_off();
    t_groups();
    t_group_wide();
    t_steady();
    t_blink(8'hE9, FAST, "R9 fast");
    t_blink(8'hEA, SLOW, "R10 slow");
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule